// File: doc/BRIEF.md
# Multichannel DAC SPI Command Decoder

This block is the digital register front end of a sixteen-channel digital-to-analog converter. An SPI host sends 24-bit frames, each made of an 8-bit command and a 16-bit data word, most significant bit first, between a falling and a rising edge of an active-low chip select. The block decodes each complete frame and updates its registers:

- a per-channel staging register and a per-channel output-code register;
- a span selector;
- dither power-down, polarity, source and scaling fields.

Codes can be staged and then moved to the outputs together by a masked load command. The whole register set can be cleared by a keyed reset word. A channel's output code can be read back, and it appears on the serial output during the frame that follows the request.

The serial pins are oversampled by the system clock. A frame is acted on one clock after chip select rises, and only if exactly 24 serial clocks were seen. The outputs are the sixteen live output codes and the configuration fields, which drive the analog side directly.

Top module: `dac_cmd_decoder`

## Requirements
- R1: A frame updates registers only when chip select rises after exactly 24 rising serial clocks. Bits 23..16 of the frame are the command and bits 15..0 are the data, sent first bit = bit 23. A frame with 23, 25 or any other bit count changes nothing.
- R2: Command 0x1n (n = channel 0..15) stores the data in staging register n and leaves every output code unchanged.
- R3: Command 0x2n writes the data straight into output code n.
- R4: Command 0x30 copies staging register n into output code n for each n whose data bit n is 1. Channels with a 0 bit keep their output code.
- R5: Command 0x70 with data 0x1234 returns every register to its reset value. Command 0x70 with any other data changes nothing.
- R6: Command 0x8n latches output code n. During the next frame, that value is driven on miso_o over the first 16 bits, MSB first. miso_o changes after falling serial clock edges, so the host samples it on rising edges.
- R7: Command 0x51 writes the 16-bit dither power-down mask, where bit n = 1 powers down channel n. Command 0xB0 writes the 16-bit dither inversion mask.
- R8: Commands 0x90 and 0xA0 write bits 15..0 and 31..16 of the 32-bit dither-source field. Commands 0xC0 and 0xD0 do the same for the 32-bit dither-scale field. Channel n uses bits 2n+1..2n, and scale codes 0/1/2/3 mean gain 1, 0.75, 0.5 and 0.25.
- R9: Command 0x40 writes data bits 2..0 to the span code, which selects one of 8 output ranges.
- R10: After rst_ni the output codes and staging registers are 0, the dither power-down mask is 0xFFFF, and the span, source, scale and inversion fields are 0.
- R11: With CODE_W below 16, codes are left-justified and written with their low 16-CODE_W bits forced to 0.
- R12: Commands not listed above, including 0x3F and 0x50, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock |
| cs_ni | input | 1 | Active-low frame select |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial readback data to host |
| dac_codes_o | output | 256 | Output codes, channel n at bits 16n+15..16n |
| span_o | output | 3 | Output range selector |
| dith_pwr_o | output | 16 | Dither power-down mask |
| dith_inv_o | output | 16 | Dither polarity inversion mask |
| dith_src_o | output | 32 | Dither source, 2 bits per channel |
| dith_scl_o | output | 32 | Dither scale, 2 bits per channel |

## Verification
The hardest state to reach is a staged code that differs from the live code on some channels but not others, followed by a load whose mask picks only part of them. The vector table first stages different values on two channels. It then loads each channel with its own mask and checks the selected channel and the untouched one separately. Readback is also awkward, because the result comes out a whole frame later. The bench therefore captures miso_o bit by bit during a no-op frame and rebuilds the word. A second instance built with 12-bit codes receives the same frames, so its low-nibble clearing is seen alongside the full-width result.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  localparam int NUM_CH  = 16;
  localparam int DATA_W  = 16;
  localparam int CMD_W   = 8;
  localparam int FRAME_W = CMD_W + DATA_W;
  localparam int CH_W    = $clog2(NUM_CH);
  localparam int SEL_W   = 2 * NUM_CH;
  localparam logic [DATA_W-1:0] RESET_KEY = 16'h1234;

  typedef enum logic [3:0] {
    OP_NOP    = 4'h0,
    OP_WR_IN  = 4'h1,
    OP_WR_DAC = 4'h2,
    OP_LOAD   = 4'h3,
    OP_SPAN   = 4'h4,
    OP_DPWR   = 4'h5,
    OP_RST    = 4'h7,
    OP_READ   = 4'h8,
    OP_SRC_LO = 4'h9,
    OP_SRC_HI = 4'hA,
    OP_INV    = 4'hB,
    OP_SCL_LO = 4'hC,
    OP_SCL_HI = 4'hD
  } op_e;
endpackage

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import dac_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  input  logic [DATA_W-1:0] tx_word_i,
  output logic              miso_o,
  output logic              frame_valid_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CNT_W = $clog2(FRAME_W) + 2;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic               sclk_q, cs_q, fv_q;
  logic [FRAME_W-1:0] rx_q, tx_q;
  logic [CNT_W-1:0]   cnt_q;

  wire sclk_rise = sclk_i & ~sclk_q;
  wire sclk_fall = ~sclk_i & sclk_q;
  wire cs_fall   = cs_q & ~cs_ni;
  wire cs_rise   = ~cs_q & cs_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      fv_q   <= 1'b0;
      rx_q   <= '0;
      tx_q   <= '0;
      cnt_q  <= '0;
    end else begin
      sclk_q <= sclk_i;
      cs_q   <= cs_ni;
      fv_q   <= cs_rise && (cnt_q == CNT_FULL);
      if (cs_fall) begin
        cnt_q <= '0;
        tx_q  <= {tx_word_i, {CMD_W{1'b0}}};
      end else if (!cs_ni) begin
        if (sclk_rise) begin
          rx_q <= {rx_q[FRAME_W-2:0], mosi_i};
          if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
        if (sclk_fall) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
      end
    end
  end

  assign miso_o        = tx_q[FRAME_W-1];
  assign frame_valid_o = fv_q;
  assign cmd_o         = rx_q[FRAME_W-1:DATA_W];
  assign data_o        = rx_q[DATA_W-1:0];

  assert_frame_len_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> ($past(cnt_q) == CNT_FULL));
  assert_frame_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> $stable(rx_q));
endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
  import dac_cmd_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     frame_valid_i,
  input  logic [CMD_W-1:0]         cmd_i,
  input  logic [DATA_W-1:0]        data_i,
  output logic [NUM_CH*DATA_W-1:0] dac_codes_o,
  output logic [DATA_W-1:0]        rb_word_o,
  output logic [2:0]               span_o,
  output logic [NUM_CH-1:0]        dith_pwr_o,
  output logic [NUM_CH-1:0]        dith_inv_o,
  output logic [SEL_W-1:0]         dith_src_o,
  output logic [SEL_W-1:0]         dith_scl_o
);
  localparam logic [DATA_W-1:0] CODE_MASK = {DATA_W{1'b1}} << (DATA_W - CODE_W);
  localparam int HALF = SEL_W / 2;

  op_e            op;
  logic [CH_W-1:0] ch;
  logic           sub_zero;
  logic           is_wr_in, is_wr_dac, is_load, is_span, is_pwr, is_rst, is_read;
  logic           is_src_lo, is_src_hi, is_inv, is_scl_lo, is_scl_hi, soft_rst;
  logic [DATA_W-1:0] code_w;

  logic [DATA_W-1:0] in_q  [NUM_CH];
  logic [DATA_W-1:0] dac_q [NUM_CH];
  logic [DATA_W-1:0] rb_q;
  logic [2:0]        span_q;
  logic [NUM_CH-1:0] pwr_q, inv_q;
  logic [SEL_W-1:0]  src_q, scl_q;

  always_comb begin
    op        = op_e'(cmd_i[7:4]);
    ch        = cmd_i[CH_W-1:0];
    sub_zero  = (cmd_i[3:0] == 4'h0);
    code_w    = data_i & CODE_MASK;
    is_wr_in  = frame_valid_i && op == OP_WR_IN;
    is_wr_dac = frame_valid_i && op == OP_WR_DAC;
    is_read   = frame_valid_i && op == OP_READ;
    is_load   = frame_valid_i && op == OP_LOAD   && sub_zero;
    is_span   = frame_valid_i && op == OP_SPAN   && sub_zero;
    is_pwr    = frame_valid_i && op == OP_DPWR   && cmd_i[3:0] == 4'h1;
    is_rst    = frame_valid_i && op == OP_RST    && sub_zero;
    is_src_lo = frame_valid_i && op == OP_SRC_LO && sub_zero;
    is_src_hi = frame_valid_i && op == OP_SRC_HI && sub_zero;
    is_inv    = frame_valid_i && op == OP_INV    && sub_zero;
    is_scl_lo = frame_valid_i && op == OP_SCL_LO && sub_zero;
    is_scl_hi = frame_valid_i && op == OP_SCL_HI && sub_zero;
    soft_rst  = is_rst && data_i == RESET_KEY;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        in_q[i]  <= '0;
        dac_q[i] <= '0;
      end else if (soft_rst) begin
        in_q[i]  <= '0;
        dac_q[i] <= '0;
      end else begin
        if (is_wr_in && ch == CH_W'(i))  in_q[i]  <= code_w;
        if (is_wr_dac && ch == CH_W'(i)) dac_q[i] <= code_w;
        else if (is_load && data_i[i])   dac_q[i] <= in_q[i];
      end
    end
    assign dac_codes_o[i*DATA_W +: DATA_W] = dac_q[i];

    assert_load_sel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_load && data_i[i]) |=> (dac_q[i] == $past(in_q[i])));
    assert_load_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_load && !data_i[i]) |=> $stable(dac_q[i]));
    assert_stage_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      is_wr_in |=> $stable(dac_q[i]));
    assert_narrow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((dac_q[i] & ~CODE_MASK) == '0));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rb_q   <= '0;
      span_q <= '0;
      pwr_q  <= '1;
      inv_q  <= '0;
      src_q  <= '0;
      scl_q  <= '0;
    end else if (soft_rst) begin
      rb_q   <= '0;
      span_q <= '0;
      pwr_q  <= '1;
      inv_q  <= '0;
      src_q  <= '0;
      scl_q  <= '0;
    end else begin
      if (is_read)   rb_q   <= dac_q[ch];
      if (is_span)   span_q <= data_i[2:0];
      if (is_pwr)    pwr_q  <= data_i[NUM_CH-1:0];
      if (is_inv)    inv_q  <= data_i[NUM_CH-1:0];
      if (is_src_lo) src_q[HALF-1:0]     <= data_i[HALF-1:0];
      if (is_src_hi) src_q[SEL_W-1:HALF] <= data_i[HALF-1:0];
      if (is_scl_lo) scl_q[HALF-1:0]     <= data_i[HALF-1:0];
      if (is_scl_hi) scl_q[SEL_W-1:HALF] <= data_i[HALF-1:0];
    end
  end

  assign rb_word_o  = rb_q;
  assign span_o     = span_q;
  assign dith_pwr_o = pwr_q;
  assign dith_inv_o = inv_q;
  assign dith_src_o = src_q;
  assign dith_scl_o = scl_q;

  assert_bad_key_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rst && data_i != RESET_KEY) |=> ($stable(pwr_q) && $stable(span_q) && $stable(src_q)));
  assert_key_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (pwr_q == '1 && span_q == '0 && dac_q[0] == '0));
  assert_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_valid_i |=> ($stable(pwr_q) && $stable(inv_q) && $stable(scl_q) && $stable(rb_q)));
endmodule

// File: rtl/dac_cmd_decoder.sv
module dac_cmd_decoder
  import dac_cmd_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sclk_i,
  input  logic                     cs_ni,
  input  logic                     mosi_i,
  output logic                     miso_o,
  output logic [NUM_CH*DATA_W-1:0] dac_codes_o,
  output logic [2:0]               span_o,
  output logic [NUM_CH-1:0]        dith_pwr_o,
  output logic [NUM_CH-1:0]        dith_inv_o,
  output logic [SEL_W-1:0]         dith_src_o,
  output logic [SEL_W-1:0]         dith_scl_o
);
  logic              fv;
  logic [CMD_W-1:0]  cmd;
  logic [DATA_W-1:0] data, rb_word;

  spi_frame_rx u_rx (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .mosi_i,
    .tx_word_i(rb_word), .miso_o,
    .frame_valid_o(fv), .cmd_o(cmd), .data_o(data)
  );

  dac_reg_bank #(.CODE_W(CODE_W)) u_bank (
    .clk_i, .rst_ni,
    .frame_valid_i(fv), .cmd_i(cmd), .data_i(data),
    .dac_codes_o, .rb_word_o(rb_word), .span_o,
    .dith_pwr_o, .dith_inv_o, .dith_src_o, .dith_scl_o
  );
endmodule

// File: tb/dac_cmd_decoder_tb.sv
module dac_cmd_decoder_tb;
  logic clk = 0, rst_ni = 0, sclk = 0, cs_n = 1, mosi = 0;
  logic miso, miso_n;
  logic [255:0] codes, codes_n;
  logic [2:0] span, span_n;
  logic [15:0] pwr, inv, pwr_n, inv_n;
  logic [31:0] src, scl, src_n, scl_n;
  logic [23:0] rx_bits;
  int nvec = 0, nfail = 0;

  always #2 clk = ~clk;

  dac_cmd_decoder u_dut (
    .clk_i(clk), .rst_ni, .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi), .miso_o(miso),
    .dac_codes_o(codes), .span_o(span), .dith_pwr_o(pwr), .dith_inv_o(inv),
    .dith_src_o(src), .dith_scl_o(scl));

  dac_cmd_decoder #(.CODE_W(12)) u_dut_narrow (
    .clk_i(clk), .rst_ni, .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi), .miso_o(miso_n),
    .dac_codes_o(codes_n), .span_o(span_n), .dith_pwr_o(pwr_n), .dith_inv_o(inv_n),
    .dith_src_o(src_n), .dith_scl_o(scl_n));

  // {cmd, data, check channel, expected code, requirement}
  localparam logic [47:0] VEC [11] = '{
    {8'h23, 16'hBEEF, 4'h3, 16'hBEEF, 4'd3},  // R3 direct write
    {8'h15, 16'h1111, 4'h5, 16'h0000, 4'd2},  // R2 staging only
    {8'h1A, 16'hAAAA, 4'hA, 16'h0000, 4'd2},  // R2 staging only
    {8'h30, 16'h0020, 4'h5, 16'h1111, 4'd4},  // R4 selected channel
    {8'h30, 16'h0020, 4'hA, 16'h0000, 4'd4},  // R4 unselected keeps
    {8'h30, 16'h0400, 4'hA, 16'hAAAA, 4'd4},  // R4 other channel
    {8'h2F, 16'hFFFF, 4'hF, 16'hFFFF, 4'd3},  // R3 top channel
    {8'h20, 16'h0001, 4'h0, 16'h0001, 4'd3},  // R3 channel 0
    {8'h50, 16'h1234, 4'h3, 16'hBEEF, 4'd12}, // R12 unused command
    {8'h3F, 16'hFFFF, 4'h0, 16'h0001, 4'd12}, // R12 load with bad subcode
    {8'h70, 16'h1235, 4'h3, 16'hBEEF, 4'd5}   // R5 wrong key
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] cmd, input logic [15:0] data, input int nbits);
    logic [23:0] w;
    w = {cmd, data};
    @(negedge clk); cs_n = 0;
    repeat (4) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      mosi = (b < 24) ? w[23-b] : 1'b0;
      repeat (4) @(negedge clk);
      if (b < 24) rx_bits[23-b] = miso;
      sclk = 1;
      repeat (4) @(negedge clk);
      sclk = 0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1;
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [15:0] ch_code(input logic [255:0] v, input int c);
    return v[c*16 +: 16];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    repeat (2) @(negedge clk);
    // R10 reset state
    check("R10 codes", {16'h0, 16'h0} | codes[31:0] | codes[255:224], 32'h0);
    check("R10 dither power", {16'h0, pwr}, 32'h0000FFFF);
    check("R10 span/inv", {13'h0, span, inv}, 32'h0);
    check("R10 src/scl", src | scl, 32'h0);

    for (int i = 0; i < 11; i++) begin
      send(VEC[i][47:40], VEC[i][39:24], 24);
      if (ch_code(codes, int'(VEC[i][23:20])) !== VEC[i][19:4]) begin
        nfail++;
        $display("FAIL R%0d vector %0d actual=%h expected=%h", VEC[i][3:0], i,
                 ch_code(codes, int'(VEC[i][23:20])), VEC[i][19:4]);
      end
      nvec++;
    end

    // R11 narrow instance keeps only upper 12 bits
    check("R11 narrow code", {16'h0, ch_code(codes_n, 3)}, 32'h0000BEE0);
    check("R11 narrow top", {16'h0, ch_code(codes_n, 15)}, 32'h0000FFF0);

    // R1 short and long frames discarded
    send(8'h21, 16'h5555, 23);
    check("R1 short frame", {16'h0, ch_code(codes, 1)}, 32'h0);
    send(8'h21, 16'h5555, 25);
    check("R1 long frame", {16'h0, ch_code(codes, 1)}, 32'h0);
    send(8'h21, 16'h5555, 24);
    check("R1 exact frame", {16'h0, ch_code(codes, 1)}, 32'h00005555);

    // R7 dither power and inversion
    send(8'h51, 16'h00F0, 24);
    check("R7 dither power", {16'h0, pwr}, 32'h000000F0);
    send(8'hB0, 16'h8001, 24);
    check("R7 dither invert", {16'h0, inv}, 32'h00008001);

    // R8 source and scale halves
    send(8'h90, 16'h1234, 24);
    send(8'hA0, 16'hABCD, 24);
    check("R8 dither source", src, 32'hABCD1234);
    send(8'hD0, 16'h00C0, 24);
    check("R8 scale high only", scl, 32'h00C00000);
    send(8'hC0, 16'h0003, 24);
    check("R8 scale ch0 quarter", scl, 32'h00C00003);

    // R9 span uses low three bits
    send(8'h40, 16'hFFFE, 24);
    check("R9 span", {29'h0, span}, 32'd6);

    // R6 readback in following frame
    send(8'h83, 16'h0000, 24);
    send(8'h00, 16'h0000, 24);
    check("R6 readback ch3", {16'h0, rx_bits[23:8]}, 32'h0000BEEF);
    send(8'h81, 16'h0000, 24);
    send(8'h00, 16'h0000, 24);
    check("R6 readback ch1", {16'h0, rx_bits[23:8]}, 32'h00005555);

    // R5 keyed reset
    send(8'h70, 16'h1234, 24);
    check("R5 keyed reset codes", {ch_code(codes, 3), ch_code(codes, 15)}, 32'h0);
    check("R5 keyed reset power", {13'h0, span, pwr}, 32'h0000FFFF);
    check("R5 keyed reset fields", src | scl | {16'h0, inv}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule